// File: doc/BRIEF.md
# Stream Packet Framer with Header Insertion

This block turns a stream of 32-bit payload samples into 64-bit packets with a header in front. Each input beat carries one sample on the data lane and a 128-bit sideband. The upper 64 bits of the sideband are a packet header and the lower 64 bits are a timestamp. The block stores the whole payload of one packet. It takes the sideband from the beat that ends the packet, then sends a header word. If the header's time flag is set, the timestamp word follows. The payload comes last, two samples to a word.

The byte length in the header is known only once the input packet has ended. This is why the block buffers a full packet before it sends anything. It fills in the length field itself. It can also stamp its own 12-bit sequence count in place of the one on the sideband. A parameter sets the payload buffer to 2^BUF_LOG2 words of 64 bits, so a packet may hold at most 2·2^BUF_LOG2 samples. A clear input zeroes the sequence count and drops any packet held in the buffer.

Top module: `pkf_framer`

## Requirements
- R1: After reset, m_tvalid is low and s_tready is high.
- R2: Payload samples are packed two per output word in arrival order. The earlier sample goes in bits [63:32] and the later one in bits [31:0]. When a packet has an odd number of samples, bits [31:0] of its final word are zero.
- R3: The header word is sent first. It copies these sideband fields: type (bits 127:126 to word bits 63:62), time flag (125 to 61), end-of-burst (124 to 60), source ID (95:80 to 31:16) and destination ID (79:64 to 15:0).
- R4: Header bits [47:32] hold the byte length. This is 4 × sample count + 8, or 4 × sample count + 16 when the time flag is set.
- R5: The second word is the timestamp (sideband bits 63:0) when the time flag is set, and the payload starts there when it is clear.
- R6: With EXT_SEQ=0, header bits [59:48] hold an internal count. The count starts at 0, rises by one for each packet fully sent, and wraps from 4095 to 0.
- R7: A one-cycle pulse on clear sets the internal count to 0. It drops any buffered or partly received packet and leaves s_tready high.
- R8: With EXT_SEQ=1, header bits [59:48] carry sideband bits [123:112] from the packet's last beat.
- R9: m_tlast is high on the final payload word of each packet and on no other word.
- R10: s_tready is low from the beat that carries s_tlast until the final word of that packet is accepted, so input and output never overlap.
- R11: A packet of 2·2^BUF_LOG2 samples is accepted. After that many samples with no s_tlast, s_tready stays low.
- R12: While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values.
- R13: Sideband values on beats other than the last one have no effect on the header or the timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clear | input | 1 | Zeroes the sequence count and drops the buffered packet |
| s_tdata | input | 32 | Payload sample |
| s_tuser | input | 128 | Sideband: header [127:64], timestamp [63:0] |
| s_tlast | input | 1 | Last sample of the input packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with s_tvalid |
| m_tdata | output | 64 | Output packet word |
| m_tlast | output | 1 | Final word of the output packet |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Output word taken when high with m_tvalid |

## Verification
Every payload length from 1 to the buffer's 16-sample limit is sent, each with the time flag clear and set. Odd and even lengths test the zero padding, and the time flag tests the length offset and whether the timestamp word appears. Each of these shapes is received under three m_tready patterns: always ready, ready every other cycle, and ready every third cycle. These patterns separate correct holding of the output from words that are lost or repeated. Earlier beats carry a scrambled sideband, which shows that only the final beat sets the header. A long run of 4097 short packets checks the sequence wrap. A second instance in sideband-sequence mode runs next to the first. A filled buffer without an end beat checks the stall and its release by clear.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
  localparam int SAMPLE_W = 32;
  localparam int WORD_W   = 64;
  localparam int SIDE_W   = 128;
  localparam int SEQ_W    = 12;

  typedef struct packed {
    logic [1:0]       kind;
    logic             timed;
    logic             burst_end;
    logic [SEQ_W-1:0] seq;
    logic [15:0]      len;
    logic [15:0]      src;
    logic [15:0]      dst;
  } hdr_t;

  typedef enum logic [1:0] {
    E_FILL = 2'd0,
    E_HDR  = 2'd1,
    E_TS   = 2'd2,
    E_DATA = 2'd3
  } emit_st_t;
endpackage

// File: rtl/pkf_pack.sv
module pkf_pack
  import pkf_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int WC_W  = ADDR_W + 1,
  localparam int SC_W  = ADDR_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                smp_last,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_word,
  output logic                full,
  output logic [SC_W-1:0]     smp_cnt
);
  logic [SAMPLE_W-1:0] hi_q;
  logic                half_q, half_d;
  logic [WC_W-1:0]     wcnt_q, wcnt_d;
  logic [SC_W-1:0]     scnt_q, scnt_d;
  logic                hi_en;

  always_comb begin
    half_d  = half_q;
    wcnt_d  = wcnt_q;
    scnt_d  = scnt_q;
    wr_en   = 1'b0;
    wr_word = '0;
    hi_en   = 1'b0;
    if (restart) begin
      half_d = 1'b0;
      wcnt_d = '0;
      scnt_d = '0;
    end else if (take) begin
      scnt_d = scnt_q + SC_W'(1);
      if (half_q) begin
        wr_en   = 1'b1;
        wr_word = {hi_q, smp};
        half_d  = 1'b0;
        wcnt_d  = wcnt_q + WC_W'(1);
      end else if (smp_last) begin
        wr_en   = 1'b1;
        wr_word = {smp, {SAMPLE_W{1'b0}}};
        wcnt_d  = wcnt_q + WC_W'(1);
      end else begin
        hi_en  = 1'b1;
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      wcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      half_q <= half_d;
      wcnt_q <= wcnt_d;
      scnt_q <= scnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= smp;
    end
  end

  assign wr_addr = wcnt_q[ADDR_W-1:0];
  assign full    = (wcnt_q == WC_W'(DEPTH));
  assign smp_cnt = scnt_q;
endmodule

// File: rtl/pkf_store.sv
module pkf_store
  import pkf_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_word;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/pkf_seq.sv
module pkf_seq
  import pkf_pkg::*;
#(
  parameter bit EXT_SEQ = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             capture,
  input  logic             advance,
  input  logic [SEQ_W-1:0] side_seq,
  output logic [SEQ_W-1:0] seq
);
  logic [SEQ_W-1:0] seq_q, seq_d;

  generate
    if (EXT_SEQ) begin : g_ext
      always_comb begin
        seq_d = seq_q;
        if (capture) seq_d = side_seq;
      end
    end else begin : g_int
      always_comb begin
        seq_d = seq_q;
        if (clear)        seq_d = '0;
        else if (advance) seq_d = seq_q + SEQ_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else        seq_q <= seq_d;
  end

  assign seq = seq_q;
endmodule

// File: rtl/pkf_emit.sv
module pkf_emit
  import pkf_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int NW_W  = ADDR_W + 1,
  localparam int SC_W  = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              capture,
  input  logic [SIDE_W-1:0] side,
  input  logic [SC_W-1:0]   nsamp,
  input  logic [SEQ_W-1:0]  seq,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] o_data,
  output logic              o_last,
  output logic              o_valid,
  input  logic              o_ready,
  output logic              busy,
  output logic              sent
);
  emit_st_t          st_q, st_d;
  hdr_t              hdr_q, hdr_d, hdr_out;
  logic [63:0]       ts_q, ts_d;
  logic [NW_W-1:0]   nw_q, nw_d;
  logic [NW_W-1:0]   ptr_q, ptr_d;
  logic              fin;

  assign fin = (st_q == E_DATA) && (ptr_q == nw_q - NW_W'(1));

  always_comb begin
    st_d  = st_q;
    hdr_d = hdr_q;
    ts_d  = ts_q;
    nw_d  = nw_q;
    ptr_d = ptr_q;
    sent  = 1'b0;
    if (flush) begin
      st_d  = E_FILL;
      ptr_d = '0;
    end else begin
      case (st_q)
        E_FILL: begin
          if (capture) begin
            hdr_d     = hdr_t'(side[127:64]);
            hdr_d.len = 16'({nsamp, 2'b00}) + (side[125] ? 16'd16 : 16'd8);
            ts_d      = side[63:0];
            nw_d      = NW_W'((nsamp + SC_W'(1)) >> 1);
            ptr_d     = '0;
            st_d      = E_HDR;
          end
        end
        E_HDR: begin
          if (o_ready) st_d = hdr_q.timed ? E_TS : E_DATA;
        end
        E_TS: begin
          if (o_ready) st_d = E_DATA;
        end
        E_DATA: begin
          if (o_ready) begin
            if (fin) begin
              st_d  = E_FILL;
              ptr_d = '0;
              sent  = 1'b1;
            end else begin
              ptr_d = ptr_q + NW_W'(1);
            end
          end
        end
        default: st_d = E_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= E_FILL;
      hdr_q <= '0;
      ts_q  <= '0;
      nw_q  <= '0;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      hdr_q <= hdr_d;
      ts_q  <= ts_d;
      nw_q  <= nw_d;
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    hdr_out     = hdr_q;
    hdr_out.seq = seq;
    case (st_q)
      E_HDR:   o_data = hdr_out;
      E_TS:    o_data = ts_q;
      E_DATA:  o_data = rd_word;
      default: o_data = '0;
    endcase
  end

  assign rd_addr = ptr_q[ADDR_W-1:0];
  assign o_valid = (st_q != E_FILL);
  assign o_last  = fin;
  assign busy    = (st_q != E_FILL);
endmodule

// File: rtl/pkf_framer.sv
module pkf_framer
  import pkf_pkg::*;
#(
  parameter int BUF_LOG2 = 5,
  parameter bit EXT_SEQ  = 1'b0,
  localparam int SC_W    = BUF_LOG2 + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [31:0]   s_tdata,
  input  logic [127:0]  s_tuser,
  input  logic          s_tlast,
  input  logic          s_tvalid,
  output logic          s_tready,
  output logic [63:0]   m_tdata,
  output logic          m_tlast,
  output logic          m_tvalid,
  input  logic          m_tready
);
  logic                take, capture, restart, full, busy, sent;
  logic                wr_en;
  logic [BUF_LOG2-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0]   wr_word, rd_word;
  logic [SC_W-1:0]     smp_cnt, nsamp;
  logic [SEQ_W-1:0]    seq;

  assign s_tready = !busy && !full;
  assign take     = s_tvalid && s_tready;
  assign capture  = take && s_tlast && !clear;
  assign restart  = clear || sent;
  assign nsamp    = smp_cnt + SC_W'(1);

  pkf_pack #(.ADDR_W(BUF_LOG2)) u_pack (
    .clk(clk), .rst_n(rst_n), .restart(restart), .take(take),
    .smp(s_tdata), .smp_last(s_tlast),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
    .full(full), .smp_cnt(smp_cnt)
  );

  pkf_store #(.ADDR_W(BUF_LOG2)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  pkf_seq #(.EXT_SEQ(EXT_SEQ)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(clear), .capture(capture),
    .advance(sent), .side_seq(s_tuser[123:112]), .seq(seq)
  );

  pkf_emit #(.ADDR_W(BUF_LOG2)) u_emit (
    .clk(clk), .rst_n(rst_n), .flush(clear), .capture(capture),
    .side(s_tuser), .nsamp(nsamp), .seq(seq),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .o_data(m_tdata), .o_last(m_tlast), .o_valid(m_tvalid), .o_ready(m_tready),
    .busy(busy), .sent(sent)
  );
endmodule

// File: rtl/pkf_framer_chk.sv
module pkf_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clear,
  input logic        s_tvalid,
  input logic        s_tready,
  input logic        s_tlast,
  input logic [63:0] m_tdata,
  input logic        m_tlast,
  input logic        m_tvalid,
  input logic        m_tready
);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tready && m_tvalid));

  assert_end_starts_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast && !clear) |=> (m_tvalid && !s_tready));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && !clear) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast && !clear) |=> !m_tvalid);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!m_tvalid && s_tready));
endmodule

bind pkf_framer pkf_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
  .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready)
);

// File: tb/pkf_framer_tb.sv
module pkf_framer_tb;
  localparam int L    = 3;
  localparam int MAXS = 2 << L;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic [31:0]  s_tdata = '0;
  logic [127:0] s_tuser = '0;
  logic         s_tlast = 1'b0;
  logic         s_tvalid = 1'b0;
  logic         m_tready = 1'b0;
  logic         rdy_a, rdy_b, last_a, last_b, val_a, val_b;
  logic [63:0]  dat_a, dat_b;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  logic [11:0] exp_seq = '0;
  int pk = 0;

  always #5 clk = ~clk;

  pkf_framer #(.BUF_LOG2(L), .EXT_SEQ(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(rdy_a),
    .m_tdata(dat_a), .m_tlast(last_a), .m_tvalid(val_a), .m_tready(m_tready)
  );

  pkf_framer #(.BUF_LOG2(L), .EXT_SEQ(1'b1)) u_ext (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(rdy_b),
    .m_tdata(dat_b), .m_tlast(last_b), .m_tvalid(val_b), .m_tready(m_tready)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s pkt=%0d actual=%h expected=%h", tag, pk, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic logic [31:0] smp(input int p, input int i);
    return {16'(p), 16'(i + 1)};
  endfunction

  task automatic send(input int n, input bit tf, input bit eob, input logic [1:0] kind,
                      input logic [11:0] sseq, input logic [15:0] src, input logic [15:0] dst,
                      input logic [63:0] ts, input bit do_last);
    for (int i = 0; i < n; i++) begin
      bit fin;
      fin      = do_last && (i == n - 1);
      s_tvalid = 1'b1;
      s_tdata  = smp(pk, i);
      s_tlast  = fin;
      if (fin) s_tuser = {kind, tf, eob, sseq, 16'h0, src, dst, ts};
      else     s_tuser = ~{kind, tf, eob, sseq, 16'h5a5a, src, dst, ts};
      forever begin
        @(negedge clk);
        if (rdy_a) break;
        @(posedge clk);
        #1;
      end
      @(posedge clk);
      #1;
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic run_pkt(input int n, input bit tf, input int mode, input bit eob,
                         input logic [1:0] kind, input logic [15:0] src, input logic [15:0] dst);
    logic [63:0] ts;
    logic [11:0] sseq;
    logic [63:0] ga [0:MAXS+2];
    logic [63:0] gb [0:MAXS+2];
    bit          gl [0:MAXS+2];
    int nw, cyc, nexp;
    bit done, stall, ok_rdy, ok_hold;
    logic [63:0] held;
    ts   = {32'hC0DE0000 | 32'(pk), 32'(n * 977)};
    sseq = 12'(pk * 37 + 5);
    send(n, tf, eob, kind, sseq, src, dst, ts, 1'b1);
    nw = 0; cyc = 0; done = 0; stall = 0; ok_rdy = 1; ok_hold = 1; held = '0;
    while (!done && cyc < 400) begin
      case (mode)
        0: m_tready = 1'b1;
        1: m_tready = (cyc % 2) == 1;
        default: m_tready = (cyc % 3) == 2;
      endcase
      @(negedge clk);
      if (val_a) begin
        if (rdy_a || rdy_b) ok_rdy = 0;
        if (stall && dat_a != held) ok_hold = 0;
        if (m_tready) begin
          ga[nw] = dat_a; gb[nw] = dat_b; gl[nw] = last_a;
          nw++;
          stall = 0;
          if (last_a || nw > MAXS + 2) done = 1;
        end else begin
          stall = 1;
          held  = dat_a;
        end
      end
      @(posedge clk);
      #1;
      cyc++;
    end
    m_tready = 1'b0;
    nexp = 1 + int'(tf) + (n + 1) / 2;
    chk(nw == nexp, "R5 word count", 64'(nw), 64'(nexp));
    chk(ok_rdy, "R10 s_tready low while sending", 64'(ok_rdy), 64'd1);
    chk(ok_hold, "R12 data held under stall", 64'(ok_hold), 64'd1);
    if (nw == nexp) begin
      logic [63:0] eh;
      bit tl_ok;
      eh = {kind, tf, eob, 12'h0, 16'h0, src, dst};
      chk({ga[0][63:60], ga[0][31:0]} == {eh[63:60], eh[31:0]}, "R3 R13 header fields",
          ga[0], eh);
      chk(ga[0][47:32] == 16'(4 * n + (tf ? 16 : 8)), "R4 byte length",
          64'(ga[0][47:32]), 64'(4 * n + (tf ? 16 : 8)));
      chk(ga[0][59:48] == exp_seq, "R6 internal sequence", 64'(ga[0][59:48]), 64'(exp_seq));
      chk(gb[0][59:48] == sseq, "R8 sideband sequence", 64'(gb[0][59:48]), 64'(sseq));
      if (tf) chk(ga[1] == ts, "R5 R13 timestamp word", ga[1], ts);
      for (int k = 0; k < (n + 1) / 2; k++) begin
        logic [63:0] ew;
        ew = {smp(pk, 2 * k), (2 * k + 1 < n) ? smp(pk, 2 * k + 1) : 32'h0};
        chk(ga[1 + int'(tf) + k] == ew, "R2 payload packing", ga[1 + int'(tf) + k], ew);
      end
      tl_ok = 1;
      for (int k = 0; k < nexp; k++) if (gl[k] != (k == nexp - 1)) tl_ok = 0;
      chk(tl_ok, "R9 last on final word only", 64'(tl_ok), 64'd1);
    end
    exp_seq = exp_seq + 12'd1;
    pk++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!val_a && rdy_a, "R1 reset state", {62'h0, val_a, rdy_a}, 64'h1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    chk(!val_a && rdy_a && !val_b && rdy_b, "R1 after reset", {62'h0, val_a, rdy_a}, 64'h1);
    @(posedge clk);
    #1;

    for (int n = 1; n <= MAXS; n++)
      for (int tf = 0; tf < 2; tf++)
        for (int mode = 0; mode < 3; mode++)
          run_pkt(n, tf[0], mode, n[0], 2'(n), 16'(n * 111), 16'hBEEF ^ 16'(n));

    // R11 full buffer without end
    send(MAXS, 1'b0, 1'b0, 2'b00, 12'h0, 16'h1, 16'h2, 64'h0, 1'b0);
    @(negedge clk);
    chk(!rdy_a && !val_a, "R11 full buffer stalls input", {62'h0, rdy_a, val_a}, 64'h0);
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!rdy_a && !val_a, "R11 stall persists", {62'h0, rdy_a, val_a}, 64'h0);
    @(posedge clk);
    #1;
    clear = 1'b1;
    @(posedge clk);
    #1;
    clear = 1'b0;
    @(negedge clk);
    chk(rdy_a && !val_a, "R7 clear releases input", {62'h0, rdy_a, val_a}, 64'h2);
    @(posedge clk);
    #1;
    exp_seq = '0;
    run_pkt(3, 1'b1, 1, 1'b0, 2'b01, 16'h1234, 16'h4321);

    // R7 clear after a few packets
    run_pkt(2, 1'b0, 0, 1'b0, 2'b00, 16'h7, 16'h8);
    clear = 1'b1;
    @(posedge clk);
    #1;
    clear = 1'b0;
    exp_seq = '0;
    run_pkt(5, 1'b0, 0, 1'b1, 2'b10, 16'h9, 16'hA);

    // R6 wrap: run through all sequence values
    for (int i = 0; i < 4097; i++)
      run_pkt(1 + (i % 2), 1'b0, 0, 1'b0, 2'b00, 16'(i), 16'h55);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule